// File: doc/BRIEF.md
# System-Management Memory Access Controller

This block guards the memory set aside for system-management mode. It holds two small control registers and a 16-bit extended-size register behind a byte-wide write port. From their contents, the mode of the current access and its address, it decides where each access goes. An access can reach the protected RAM. It can fall through to the legacy video/PCI space. It can read as all-ones with its write discarded. Or it can be left alone for the rest of the memory map to handle. The storage itself lies outside the block; only the routing decision is made here.

Three windows are governed. The first is the legacy 128 KB window at 0x000A0000–0x000BFFFF. The second is a 128 KB high alias of the same RAM at 0xFEDA0000–0xFEDBFFFF. The third is a top segment of configurable size that ends at the below-4 GB memory top. Software opens, enables and sizes these windows. Once it sets the lock bit, the configuration is frozen until reset.

Top module: `smm_window_ctrl`

## Requirements
- R1: Register map, selected by `wr_addr`/`rd_addr`: address 0 is the control register, with bit0 global enable, bit1 lock and bit2 open. Address 1 is the segment register, with bit0 segment enable, bits[2:1] size code and bit3 high enable. Addresses 2 and 3 are the low and high bytes of the extended-size register. Bits not listed read 0. `rd_data` follows `rd_addr` combinationally.
- R2: After reset the control and segment registers read 0x00. The extended-size register reads 0xFFFF when the parameter `EXT_MB` is nonzero, and 0x0000 otherwise.
- R3: Any write that leaves the lock bit set clears the open bit in the same update, including a write that sets open and lock together. The lock bit stays set until reset.
- R4: While lock is set, writes to the control and segment registers change nothing. Reset clears lock and restores full write access.
- R5: For a normal access in the legacy window, `sel_ram` is asserted when open=1 and high enable=0. Otherwise `sel_pci` is asserted.
- R6: For a normal access in the high alias, `sel_ram` is asserted only when open=1 and high enable=1. Otherwise no select output is asserted.
- R7: For a system-management access with global enable=1, the legacy window selects RAM when high enable=0, and the high alias selects RAM when high enable=1. In all other cases such an access is routed as a normal one would be.
- R8: Segment size in MB is 0 when segment enable is 0. Otherwise size codes 0, 1, 2 and 3 give 1, 2, 8 and `EXT_MB`. `seg_base_mb` equals `MEM_TOP_MB` minus that size.
- R9: An access in [seg_base_mb·1 MB, MEM_TOP_MB·1 MB) with a nonzero size asserts `sel_ones` when normal and `sel_ram` when in system-management mode. With size 0 the segment does not exist.
- R10: A write to address 2 or 3 updates that byte. If the resulting 16-bit value is 0xFFFF and `EXT_MB` is nonzero, the register takes the value `EXT_MB` instead.
- R11: Every output reflects a register write from the cycle after the write edge, not before. An `EXT_MB` above `EXT_MB_MAX` is rejected at elaboration.
- R12: At most one of `sel_ram`, `sel_pci` and `sel_ones` is asserted at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Register selected for writing |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 2 | Register selected for reading |
| rd_data | output | 8 | Read byte |
| acc_addr | input | 32 | Address of the access being routed |
| acc_smm | input | 1 | Access issued in system-management mode |
| sel_ram | output | 1 | Route to protected RAM |
| sel_pci | output | 1 | Route legacy window to video/PCI space |
| sel_ones | output | 1 | Read all-ones, discard write |
| seg_base_mb | output | 16 | Top-segment base in MB |
| seg_size_mb | output | 16 | Top-segment size in MB |

## Verification
Register state changes on the clock edge that captures a write. Every decode output and `rd_data` is combinational from that state, so each result is due exactly one edge after the write strobe. The bench applies writes at the falling edge and releases the strobe at the next falling edge. It samples one time unit later, which is after the capturing rising edge and well before the following one. For the latency requirement, one check also samples while the strobe is still high, before the edge, to confirm that the old routing still holds. Address and mode changes to the decoder are purely combinational, so they are sampled in the same half cycle.

// File: rtl/smm_win_pkg.sv
// Package: shared constants and field layouts for the system-management
// memory access controller. Assumes a 32-bit physical access address.
package smm_win_pkg;

    localparam int ADDR_W = 32;
    localparam int BYTE_W = 8;
    localparam int RA_W   = 2;
    localparam int MB_W   = 16;

    // register addresses
    localparam logic [RA_W-1:0] RA_CTRL   = 2'd0;
    localparam logic [RA_W-1:0] RA_SEG    = 2'd1;
    localparam logic [RA_W-1:0] RA_EXT_LO = 2'd2;
    localparam logic [RA_W-1:0] RA_EXT_HI = 2'd3;

    // control register bits
    localparam int B_GEN  = 0;
    localparam int B_LOCK = 1;
    localparam int B_OPEN = 2;

    // segment register bits
    localparam int B_SEG_EN = 0;
    localparam int B_SZ_LO  = 1;
    localparam int B_HI_EN  = 3;

    typedef enum logic [1:0] {
        SZ_1M  = 2'd0,
        SZ_2M  = 2'd1,
        SZ_8M  = 2'd2,
        SZ_EXT = 2'd3
    } seg_size_e;

    // fixed windows
    localparam logic [ADDR_W-1:0] LEGACY_LO = 32'h000A_0000;
    localparam logic [ADDR_W-1:0] LEGACY_HI = 32'h000B_FFFF;
    localparam logic [ADDR_W-1:0] HIGH_LO   = 32'hFEDA_0000;
    localparam logic [ADDR_W-1:0] HIGH_HI   = 32'hFEDB_FFFF;

    localparam logic [15:0] EXT_QUERY = 16'hFFFF;

endpackage

// File: rtl/smm_ctl_regs.sv
// Control and segment registers with write masks and a sticky lock.
// Assumes byte writes; a write that leaves lock set also clears open.
// While lock is set the reduced masks apply; reset restores the full masks.
module smm_ctl_regs
    import smm_win_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CTRL_RST     = 8'h00,
    parameter logic [BYTE_W-1:0] SEG_RST      = 8'h00,
    parameter logic [BYTE_W-1:0] CTRL_WM_FULL = 8'h07,
    parameter logic [BYTE_W-1:0] CTRL_WM_LOCK = 8'h00,
    parameter logic [BYTE_W-1:0] SEG_WM_FULL  = 8'h0F,
    parameter logic [BYTE_W-1:0] SEG_WM_LOCK  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic [BYTE_W-1:0] seg_q
);

    logic              locked;
    logic [BYTE_W-1:0] ctrl_wm;
    logic [BYTE_W-1:0] seg_wm;
    logic [BYTE_W-1:0] ctrl_nxt;
    logic [BYTE_W-1:0] seg_nxt;

    assign locked = ctrl_q[B_LOCK];

    // choose active write masks from the lock state
    always_comb begin
        ctrl_wm = locked ? CTRL_WM_LOCK : CTRL_WM_FULL;
        seg_wm  = locked ? SEG_WM_LOCK  : SEG_WM_FULL;
    end

    // merge write data through masks; lock forces open low
    always_comb begin
        ctrl_nxt = ctrl_q;
        seg_nxt  = seg_q;
        if (wr_en && wr_addr == RA_CTRL)
            ctrl_nxt = (ctrl_q & ~ctrl_wm) | (wr_data & ctrl_wm);
        if (wr_en && wr_addr == RA_SEG)
            seg_nxt = (seg_q & ~seg_wm) | (wr_data & seg_wm);
        if (ctrl_nxt[B_LOCK])
            ctrl_nxt[B_OPEN] = 1'b0;
    end

    // register state with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            seg_q  <= SEG_RST;
        end else begin
            ctrl_q <= ctrl_nxt;
            seg_q  <= seg_nxt;
        end
    end

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[B_LOCK] |=> ctrl_q[B_LOCK]);

    // R3
    lock_open_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[B_LOCK]) |-> !ctrl_q[B_OPEN]);

    // R4
    locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[B_LOCK] && wr_en) |=>
            ((((ctrl_q ^ $past(ctrl_q)) & ~CTRL_WM_LOCK) == 8'h00) &&
             (((seg_q ^ $past(seg_q)) & ~SEG_WM_LOCK) == 8'h00)));

endmodule

// File: rtl/smm_ext_size.sv
// Extended-size register: 16 bits written a byte at a time. When EXT_MB is
// nonzero, a write that produces the query value is answered with EXT_MB,
// and reset loads the query value.
module smm_ext_size
    import smm_win_pkg::*;
#(
    parameter int EXT_MB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [15:0]       ext_q
);

    localparam bit          HAS_EXT = (EXT_MB > 0);
    localparam logic [15:0] EXT_VAL = 16'(EXT_MB);
    localparam logic [15:0] RST_VAL = HAS_EXT ? EXT_QUERY : 16'h0000;

    logic [15:0] ext_nxt;
    logic        ext_wr;

    assign ext_wr = wr_en && (wr_addr == RA_EXT_LO || wr_addr == RA_EXT_HI);

    // byte merge, then answer a query
    always_comb begin
        ext_nxt = ext_q;
        if (wr_en && wr_addr == RA_EXT_LO) ext_nxt[7:0]  = wr_data;
        if (wr_en && wr_addr == RA_EXT_HI) ext_nxt[15:8] = wr_data;
        if (HAS_EXT && ext_wr && ext_nxt == EXT_QUERY) ext_nxt = EXT_VAL;
    end

    // register state with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= RST_VAL;
        else        ext_q <= ext_nxt;
    end

    generate
        if (HAS_EXT) begin : g_query
            // R10
            ext_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ext_wr |=> (ext_q != EXT_QUERY));
        end
    endgenerate

endmodule

// File: rtl/smm_seg_calc.sv
// Top-segment geometry: size in MB from the enable and size code, and the
// base as the memory top minus that size. Assumes the segment fits below
// the memory top.
module smm_seg_calc
    import smm_win_pkg::*;
#(
    parameter int EXT_MB     = 16,
    parameter int MEM_TOP_MB = 2048
) (
    input  logic            seg_en,
    input  logic [1:0]      size_code,
    output logic [MB_W-1:0] size_mb,
    output logic [MB_W-1:0] base_mb
);

    localparam logic [MB_W-1:0] TOP_MB = MB_W'(MEM_TOP_MB);
    localparam logic [MB_W-1:0] EXT_SZ = MB_W'(EXT_MB);

    // size decode from the code
    always_comb begin
        size_mb = '0;
        if (seg_en) begin
            case (seg_size_e'(size_code))
                SZ_1M:   size_mb = MB_W'(1);
                SZ_2M:   size_mb = MB_W'(2);
                SZ_8M:   size_mb = MB_W'(8);
                default: size_mb = EXT_SZ;
            endcase
        end
    end

    // base below the memory top
    assign base_mb = TOP_MB - size_mb;

endmodule

// File: rtl/smm_addr_decode.sv
// Routing decision for one access: protected RAM, legacy video/PCI space,
// all-ones black hole or not claimed. The top segment is checked first,
// then the legacy window, then the high alias. Purely combinational; the
// clock serves only the assertions.
module smm_addr_decode
    import smm_win_pkg::*;
#(
    parameter int MEM_TOP_MB = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_en,
    input  logic              gen_en,
    input  logic              hi_en,
    input  logic [MB_W-1:0]   seg_size_mb,
    input  logic [MB_W-1:0]   seg_base_mb,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    output logic              sel_ram,
    output logic              sel_pci,
    output logic              sel_ones
);

    localparam int             CW    = MB_W + 20;
    localparam logic [CW-1:0]  TOP_B = {MB_W'(MEM_TOP_MB), 20'h0};

    logic [CW-1:0] acc_w;
    logic          legacy_hit;
    logic          high_hit;
    logic          seg_hit;

    // window hits
    always_comb begin
        acc_w      = CW'(acc_addr);
        legacy_hit = (acc_addr >= LEGACY_LO) && (acc_addr <= LEGACY_HI);
        high_hit   = (acc_addr >= HIGH_LO) && (acc_addr <= HIGH_HI);
        seg_hit    = (seg_size_mb != '0) &&
                     (acc_w >= {seg_base_mb, 20'h0}) && (acc_w < TOP_B);
    end

    // route selection by window and mode
    always_comb begin
        sel_ram  = 1'b0;
        sel_pci  = 1'b0;
        sel_ones = 1'b0;
        if (seg_hit) begin
            if (acc_smm) sel_ram  = 1'b1;
            else         sel_ones = 1'b1;
        end else if (legacy_hit) begin
            if (acc_smm && gen_en && !hi_en)  sel_ram = 1'b1;
            else if (open_en && !hi_en)       sel_ram = 1'b1;
            else                              sel_pci = 1'b1;
        end else if (high_hit) begin
            if ((acc_smm && gen_en && hi_en) || (open_en && hi_en))
                sel_ram = 1'b1;
        end
    end

    // R12
    sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_ram, sel_pci, sel_ones}));

    // R9
    smm_no_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_smm |-> !sel_ones);

    // R6
    closed_high_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_smm && !open_en && acc_addr >= HIGH_LO && acc_addr <= HIGH_HI)
            |-> !sel_ram);

endmodule

// File: rtl/smm_window_ctrl.sv
// Top level: register file, extended-size register, segment geometry and
// access decoder. All outputs are combinational from register state and
// the access inputs, so a write shows on the outputs after its edge.
module smm_window_ctrl
    import smm_win_pkg::*;
#(
    parameter int MEM_TOP_MB = 2048,
    parameter int EXT_MB     = 16,
    parameter int EXT_MB_MAX = 4095
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [RA_W-1:0]   rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    output logic              sel_ram,
    output logic              sel_pci,
    output logic              sel_ones,
    output logic [MB_W-1:0]   seg_base_mb,
    output logic [MB_W-1:0]   seg_size_mb
);

    // R11: configuration limits checked at elaboration
    generate
        if (EXT_MB < 0 || EXT_MB > EXT_MB_MAX) begin : g_bad_ext
            $error("extended segment size exceeds its limit");
        end
        if (MEM_TOP_MB < 1 || MEM_TOP_MB > 4096) begin : g_bad_top
            $error("memory top out of range");
        end
    endgenerate

    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] seg_q;
    logic [15:0]       ext_q;

    smm_ctl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .seg_q   (seg_q)
    );

    smm_ext_size #(.EXT_MB(EXT_MB)) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ext_q   (ext_q)
    );

    smm_seg_calc #(.EXT_MB(EXT_MB), .MEM_TOP_MB(MEM_TOP_MB)) u_seg (
        .seg_en    (seg_q[B_SEG_EN]),
        .size_code (seg_q[B_SZ_LO +: 2]),
        .size_mb   (seg_size_mb),
        .base_mb   (seg_base_mb)
    );

    smm_addr_decode #(.MEM_TOP_MB(MEM_TOP_MB)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_en     (ctrl_q[B_OPEN]),
        .gen_en      (ctrl_q[B_GEN]),
        .hi_en       (seg_q[B_HI_EN]),
        .seg_size_mb (seg_size_mb),
        .seg_base_mb (seg_base_mb),
        .acc_addr    (acc_addr),
        .acc_smm     (acc_smm),
        .sel_ram     (sel_ram),
        .sel_pci     (sel_pci),
        .sel_ones    (sel_ones)
    );

    // read-back multiplexer
    always_comb begin
        case (rd_addr)
            RA_CTRL:   rd_data = ctrl_q;
            RA_SEG:    rd_data = seg_q;
            RA_EXT_LO: rd_data = ext_q[7:0];
            default:   rd_data = ext_q[15:8];
        endcase
    end

endmodule

// File: tb/smm_window_ctrl_tb.sv
// Bench: a vector table for routing, then directed tests for reset,
// read-back, geometry, extended size, lock and latency.
module smm_window_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [31:0] acc_addr = '0;
    logic        acc_smm = 1'b0;
    logic        sel_ram, sel_pci, sel_ones;
    logic [15:0] seg_base_mb, seg_size_mb;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smm_window_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .acc_addr(acc_addr), .acc_smm(acc_smm), .sel_ram(sel_ram),
        .sel_pci(sel_pci), .sel_ones(sel_ones),
        .seg_base_mb(seg_base_mb), .seg_size_mb(seg_size_mb)
    );

    // {req, ctrl, seg, addr, smm, {ram,pci,ones}}
    localparam logic [55:0] VEC [0:NV-1] = '{
        {4'd5,  8'h00, 8'h00, 32'h000A_0000, 1'b0, 3'b010}, // R5 closed
        {4'd5,  8'h04, 8'h00, 32'h000B_0000, 1'b0, 3'b100}, // R5 open
        {4'd5,  8'h04, 8'h08, 32'h000A_0000, 1'b0, 3'b010}, // R5 open+hi
        {4'd6,  8'h04, 8'h08, 32'hFEDA_0000, 1'b0, 3'b100}, // R6 shown
        {4'd6,  8'h00, 8'h08, 32'hFEDB_FFFC, 1'b0, 3'b000}, // R6 closed
        {4'd6,  8'h04, 8'h00, 32'hFEDA_0000, 1'b0, 3'b000}, // R6 hi off
        {4'd7,  8'h01, 8'h00, 32'h000A_0000, 1'b1, 3'b100}, // R7 low
        {4'd7,  8'h01, 8'h08, 32'hFEDA_1000, 1'b1, 3'b100}, // R7 high
        {4'd7,  8'h01, 8'h08, 32'h000A_0000, 1'b1, 3'b010}, // R7 fallthrough
        {4'd7,  8'h00, 8'h00, 32'h000A_0000, 1'b1, 3'b010}, // R7 gen off
        {4'd9,  8'h00, 8'h01, 32'h7FF0_0000, 1'b0, 3'b001}, // R9 1MB hole
        {4'd9,  8'h00, 8'h01, 32'h7FEF_FFFF, 1'b0, 3'b000}, // R9 below
        {4'd9,  8'h00, 8'h01, 32'h7FF0_0000, 1'b1, 3'b100}, // R9 smm ram
        {4'd9,  8'h00, 8'h00, 32'h7FF0_0000, 1'b0, 3'b000}, // R9 size 0
        {4'd9,  8'h00, 8'h05, 32'h7F80_0000, 1'b0, 3'b001}, // R9 8MB
        {4'd9,  8'h00, 8'h05, 32'h7F7F_FFFF, 1'b0, 3'b000}, // R9 8MB below
        {4'd9,  8'h00, 8'h07, 32'h7F00_0000, 1'b0, 3'b001}, // R9 ext 16MB
        {4'd9,  8'h00, 8'h03, 32'h7FE0_0000, 1'b0, 3'b001}, // R9 2MB
        {4'd5,  8'h04, 8'h08, 32'h000C_0000, 1'b0, 3'b000}  // R5 past window
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        #1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic [7:0] d;
        do_reset();

        // R2 reset state
        rd(2'd0, d); chk("R2 ctrl", d, 8'h00);
        rd(2'd1, d); chk("R2 seg", d, 8'h00);
        rd(2'd2, d); chk("R2 ext lo", d, 8'hFF);
        rd(2'd3, d); chk("R2 ext hi", d, 8'hFF);
        acc_addr = 32'h000A_0000; acc_smm = 1'b0; #1;
        chk("R2 route", {29'd0, sel_ram, sel_pci, sel_ones}, 32'b010);

        // R1 unused bits read zero
        wr(2'd0, 8'hF5); rd(2'd0, d); chk("R1 ctrl mask", d, 8'h05);
        wr(2'd1, 8'hFF); rd(2'd1, d); chk("R1 seg mask", d, 8'h0F);

        // routing table: R5 R6 R7 R9 R12
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, VEC[i][51:44]);
            wr(2'd1, VEC[i][43:36]);
            acc_addr = VEC[i][35:4];
            acc_smm  = VEC[i][3];
            #1;
            n_chk++;
            if ({sel_ram, sel_pci, sel_ones} !== VEC[i][2:0]) begin
                n_fail++;
                $display("FAIL R%0d vec %0d actual=%b expected=%b",
                         VEC[i][55:52], i, {sel_ram, sel_pci, sel_ones}, VEC[i][2:0]);
            end
            chk("R12 exclusive", 32'($countones({sel_ram, sel_pci, sel_ones}) <= 1), 32'd1);
        end
        acc_smm = 1'b0;

        // R8 geometry
        wr(2'd1, 8'h01); chk("R8 1MB", seg_size_mb, 16'd1); chk("R8 base1", seg_base_mb, 16'd2047);
        wr(2'd1, 8'h03); chk("R8 2MB", seg_size_mb, 16'd2);
        wr(2'd1, 8'h05); chk("R8 8MB", seg_size_mb, 16'd8);
        wr(2'd1, 8'h07); chk("R8 ext", seg_size_mb, 16'd16); chk("R8 base ext", seg_base_mb, 16'd2032);
        wr(2'd1, 8'h06); chk("R8 off", seg_size_mb, 16'd0); chk("R8 base off", seg_base_mb, 16'd2048);

        // R10 extended size query
        wr(2'd2, 8'h34); rd(2'd2, d); chk("R10 lo", d, 8'h34);
        rd(2'd3, d); chk("R10 hi kept", d, 8'hFF);
        wr(2'd3, 8'h12); rd(2'd3, d); chk("R10 hi", d, 8'h12);
        wr(2'd2, 8'hFF); rd(2'd2, d); chk("R10 partial", d, 8'hFF);
        wr(2'd3, 8'hFF);
        rd(2'd2, d); chk("R10 reply lo", d, 8'h10);
        rd(2'd3, d); chk("R10 reply hi", d, 8'h00);

        // R11 latency: old route until the write edge, new after
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        acc_addr = 32'h000A_0000;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h04;
        #1; chk("R11 before edge", {29'd0, sel_ram, sel_pci, sel_ones}, 32'b010);
        @(negedge clk); wr_en = 1'b0; #1;
        chk("R11 after edge", {29'd0, sel_ram, sel_pci, sel_ones}, 32'b100);

        // R3 lock clears open
        wr(2'd1, 8'h08);
        wr(2'd0, 8'h06); rd(2'd0, d); chk("R3 open cleared", d, 8'h02);
        acc_addr = 32'hFEDA_0000; #1;
        chk("R3 alias hidden", {29'd0, sel_ram, sel_pci, sel_ones}, 32'b000);
        // R4 frozen while locked
        wr(2'd0, 8'h05); rd(2'd0, d); chk("R4 ctrl frozen", d, 8'h02);
        wr(2'd0, 8'h00); rd(2'd0, d); chk("R3 lock sticky", d, 8'h02);
        wr(2'd1, 8'h01); rd(2'd1, d); chk("R4 seg frozen", d, 8'h08);
        chk("R4 no segment", seg_size_mb, 16'd0);

        // R4 reset restores write access; R2 defaults again
        do_reset();
        rd(2'd0, d); chk("R4 reset ctrl", d, 8'h00);
        rd(2'd2, d); chk("R2 ext after reset", d, 8'hFF);
        wr(2'd0, 8'h04); rd(2'd0, d); chk("R4 writable", d, 8'h04);
        wr(2'd0, 8'h02); rd(2'd0, d); chk("R3 lock alone", d, 8'h02);

        summary();
    end

endmodule